// File: doc/BRIEF.md
# Counted Serial Result Readout Port

This block is the read-only serial output of a data converter. A host supplies a serial clock and a convert-start line, and the block drives a single data line that can be put in high impedance. A rising edge on convert-start arms the port and clears a bit counter. From that point each rising edge of the serial clock presents the next bit of the held result, most significant bit first. After exactly `DATA_W` bits the port releases the line on the falling edge of the last clock and ignores any further clocks until it is armed again.

The block holds the result of the most recent conversion. The converter delivers new results on a one-cycle `res_valid` strobe. If a read is in progress when a result arrives, the block keeps the result aside and makes it the held value only after the read finishes. This means a read that starts before a conversion ends returns the earlier result.

Both host-side inputs are asynchronous and are oversampled in the `clk` domain. Each passes through a two-flop synchronizer followed by an edge register, so each serial-clock or convert-start edge takes effect on the third `clk` edge after the input changes. The tri-state is modelled by a separate enable output. The host must hold each serial-clock level for at least four `clk` cycles.

Top module: `serial_result_port`

## Requirements
- R1: After synchronous reset, `dout_oe` is 0, `dout` is 0, `rd_busy` is 0 and the held result is all zeros.
- R2: Until the first convert-start rising edge after reset, serial-clock edges leave `dout_oe` at 0.
- R3: After a convert-start rising edge, the k-th serial-clock rising edge (k = 1..DATA_W) drives `dout_oe` = 1 and places bit DATA_W-k of the held result on `dout`. Bit DATA_W-1 comes first and bit 0 last.
- R4: `dout_oe` stays 1 through the high phase of the last (DATA_W-th) clock and returns to 0 on that clock's falling edge.
- R5: Serial-clock edges after the DATA_W-th bit do not drive the line (`dout_oe` stays 0) until the next convert-start rising edge. A new read after re-arming again starts from bit DATA_W-1.
- R6: A result that arrives while no read is in progress becomes the held value at once. A read armed before a result arrives, and clocked out before it, returns the previous held value.
- R7: A result that arrives while a read is in progress does not alter the bits of that read. It becomes the held value once the read ends, so the next read returns it.
- R8: A convert-start rising edge during an unfinished read abandons it: `dout_oe` drops and the next clocks restart from bit DATA_W-1.
- R9: The transfer works with any spacing between serial clocks, from a continuous clock to widely gapped pulses, as long as each level lasts at least four `clk` cycles.
- R10: `rd_busy` is 1 from the first serial-clock rising edge of a read until that read ends (last falling edge or re-arm), and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the host inputs |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| cstart_in | input | 1 | Convert-start line; its rising edge arms the port |
| res_valid | input | 1 | One-cycle strobe marking a new conversion result |
| res_data | input | DATA_W | New conversion result |
| dout | output | 1 | Serial data, 0 while not driven |
| dout_oe | output | 1 | Output enable; 0 means high impedance |
| rd_busy | output | 1 | A read is in progress; result loading is deferred |

## Verification
The bench targets the boundary around the last bit. A counter that is off by one would either release the line during the last high phase or shift out an eleventh bit on an extra clock. It also tries results that arrive in the middle of a read; a design without deferral would corrupt the bits still to come. Re-arming part way through a read checks that the counter restarts from the top bit and that the pending result is loaded before the restarted read begins. Randomly spaced clocks with random data cover gated clocking.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  // width of a counter that must hold the values 0..n
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ser_edge_sync.sv
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
  assign fall = ~chain[STAGES-1] & last_q;

  // a detected rise leaves the level high for the next cycle
  AST_RISE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    rise |=> !fall); // R9
endmodule

// File: rtl/ser_result_hold.sv
module ser_result_hold #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              new_valid,
  input  logic [DATA_W-1:0] new_data,
  input  logic              busy,
  output logic [DATA_W-1:0] held
);
  logic [DATA_W-1:0] pend_data;
  logic              pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      held      <= '0;
      pend_data <= '0;
      pending   <= 1'b0;
    end else if (!busy) begin
      if (new_valid)    held <= new_data;
      else if (pending) held <= pend_data;
      pending <= 1'b0;
    end else if (new_valid) begin
      pend_data <= new_data;
      pending   <= 1'b1;
    end
  end

  AST_HELD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(held)); // R7
  AST_PEND_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (pending && !busy) |=> (held == $past(pend_data) || $past(new_valid))); // R7
endmodule

// File: rtl/ser_shift_engine.sv
module ser_shift_engine #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic [DATA_W-1:0] held,
  output logic              sdo,
  output logic              oe,
  output logic              busy
);
  localparam int CW = ser_port_pkg::cnt_width(DATA_W);
  localparam logic [CW-1:0] LAST = CW'(DATA_W);
  localparam logic [CW-1:0] TOP  = CW'(DATA_W - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] idx;
  logic          armed;

  assign idx = TOP - cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      oe    <= 1'b0;
      sdo   <= 1'b0;
    end else if (arm) begin
      armed <= 1'b1;
      cnt   <= '0;
      oe    <= 1'b0;
      sdo   <= 1'b0;
    end else if (armed) begin
      if (sclk_rise && cnt < LAST) begin
        oe  <= 1'b1;
        sdo <= held[idx];
        cnt <= cnt + 1'b1;
      end else if (sclk_fall && cnt == LAST) begin
        oe    <= 1'b0;
        sdo   <= 1'b0;
        armed <= 1'b0;
      end
    end
  end

  assign busy = armed && (cnt != '0);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R5
  AST_RELEASE_POINT: assert property (@(posedge clk) disable iff (rst)
    $fell(oe) |-> ($past(cnt) == LAST || $past(arm))); // R4
  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    (!sclk_rise && !arm && !sclk_fall) |=> $stable(sdo)); // R3
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!oe && !busy)); // R8
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int DATA_W    = 10,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_in,
  input  logic              cstart_in,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  output logic              dout,
  output logic              dout_oe,
  output logic              rd_busy
);
  logic sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic [DATA_W-1:0] held;
  logic sdo_q;

  ser_edge_sync #(.STAGES(SYNC_STGS)) u_sclk_sync (
    .clk(clk), .rst(rst), .async_in(sclk_in), .rise(sclk_rise), .fall(sclk_fall));
  ser_edge_sync #(.STAGES(SYNC_STGS)) u_cs_sync (
    .clk(clk), .rst(rst), .async_in(cstart_in), .rise(cs_rise), .fall(cs_fall));

  ser_result_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .new_valid(res_valid), .new_data(res_data),
    .busy(rd_busy), .held(held));

  ser_shift_engine #(.DATA_W(DATA_W)) u_engine (
    .clk(clk), .rst(rst), .arm(cs_rise), .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall), .held(held), .sdo(sdo_q), .oe(dout_oe),
    .busy(rd_busy));

  assign dout = sdo_q;

  AST_BUSY_DRIVES: assert property (@(posedge clk) disable iff (rst)
    rd_busy |-> dout_oe || !$past(cs_fall || !cs_fall)); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> !dout); // R1
endmodule

// File: tb/serial_result_port_bench.sv
module serial_result_port_bench;
  localparam int W = 10;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 0, rst = 1, sclk_in = 0, cstart_in = 0, res_valid = 0;
  logic [W-1:0] res_data = '0;
  logic dout, dout_oe, rd_busy;
  int tests = 0, fails = 0;
  bit done = 0;

  serial_result_port #(.DATA_W(W)) u_serial_result_port (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .cstart_in(cstart_in),
    .res_valid(res_valid), .res_data(res_data), .dout(dout),
    .dout_oe(dout_oe), .rd_busy(rd_busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic exp_bit(input logic [W-1:0] v, input int k);
    return v[W-k];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] v);
    @(negedge clk);
    res_valid = 1; res_data = v;
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic arm();
    @(negedge clk);
    cstart_in = 0; wait_n(4);
    cstart_in = 1; wait_n(5);
    cstart_in = 0; wait_n(2);
  endtask

  // one clock pulse; returns dout and dout_oe seen late in the high phase
  task automatic pulse(input int hi, input int lo, output logic b, output logic e);
    sclk_in = 1; wait_n(hi);
    b = dout; e = dout_oe;
    sclk_in = 0; wait_n(lo);
  endtask

  // read nb bits and compare against v's top nb bits
  task automatic read_chk(input logic [W-1:0] v, input int nb, input string req,
                          input bit rnd);
    logic b, e;
    int hi, lo;
    for (int k = 1; k <= nb; k++) begin
      hi = rnd ? 4 + int'($urandom_range(5)) : 4;
      lo = rnd ? 4 + int'($urandom_range(12)) : 4;
      pulse(hi, lo, b, e);
      chk(e == 1'b1 && b == exp_bit(v, k), req, {e, b}, {1'b1, exp_bit(v, k)});
      if (k == 1) chk(rd_busy == 1'b1, "R10", rd_busy, 1);
    end
  endtask

  initial begin
    logic b, e;
    logic [W-1:0] a, c;
    void'($urandom(32'h5eed1234));
    wait_n(4); rst = 0; wait_n(1);
    // R1 reset values
    chk(dout_oe == 0 && dout == 0 && rd_busy == 0, "R1", {dout_oe, dout, rd_busy}, 0);
    // R2 clocks before any arm are not served
    for (int i = 0; i < 3; i++) begin
      pulse(4, 4, b, e);
      chk(e == 0, "R2", e, 0);
    end
    // R1 held value zero after reset
    arm();
    read_chk('0, W, "R1", 0);
    wait_n(1);
    chk(dout_oe == 0, "R4", dout_oe, 0);
    // R6 immediate load, R3 order
    a = 10'h2D3;
    push(a);
    arm();
    read_chk(a, W, "R3", 0);
    chk(dout_oe == 0 && rd_busy == 0, "R4", {dout_oe, rd_busy}, 0);
    // R5 extra clocks ignored
    for (int i = 0; i < 3; i++) begin
      pulse(4, 4, b, e);
      chk(e == 0, "R5", e, 0);
    end
    // R6 read armed before result returns previous
    c = 10'h15A;
    arm();
    read_chk(a, 3, "R6", 0);
    // R7 result during read does not alter remaining bits
    push(c);
    for (int k = 4; k <= W; k++) begin
      pulse(4, 4, b, e);
      chk(e == 1 && b == exp_bit(a, k), "R7", {e, b}, {1'b1, exp_bit(a, k)});
    end
    chk(dout_oe == 0 && rd_busy == 0, "R10", {dout_oe, rd_busy}, 0);
    arm();
    read_chk(c, W, "R7", 0);
    // R8 abandon mid read, with pending result loaded before restart
    a = 10'h3C1;
    arm();
    read_chk(c, 5, "R8", 0);
    push(a);
    arm();
    chk(dout_oe == 0 && rd_busy == 0, "R8", {dout_oe, rd_busy}, 0);
    read_chk(a, W, "R8", 0);
    wait_n(1);
    chk(dout_oe == 0, "R4", dout_oe, 0);
    // R9 random data with random clock spacing
    for (int it = 0; it < 20; it++) begin
      a = W'($urandom);
      push(a);
      arm();
      read_chk(a, W, "R9", 1);
      chk(dout_oe == 0 && rd_busy == 0, "R4", {dout_oe, rd_busy}, 0);
    end
    // R5 re-arm after ignored clocks restarts at top bit
    pulse(4, 4, b, e);
    chk(e == 0, "R5", e, 0);
    arm();
    read_chk(a, W, "R5", 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule